// File: doc/BRIEF.md
# Bit-Plane Hybrid DCT / Haar Transform Engine

This block turns a group of eight unsigned samples into eight transform coefficients. Depending on a mode bit it produces either an 8-point 1-D cosine transform or an 8-point 1-D Haar wavelet transform. It uses no multipliers and no coefficient ROM. A single shared adder network forms one partial sum per output lane for each bit plane of the fixed coefficients. Eight 16-input selectors then walk through those planes one per cycle. Eight shift-accumulate units build the products bit-serially.

A free-running sequencer paces the work. After reset is released, it captures the sample bus and the mode bit at one clock edge. It then spends the next group period walking the bit planes from the sign plane down to plane 0. At the end of the period it presents the rounded and saturated results with a one-cycle strobe, and in that same edge it captures the next group. The sample bus and the mode bit are looked at only on those capture edges.

Top module: `bpx_xform`

## Requirements
- R1: With the captured mode bit at 0, lane k of the result equals the rounded and saturated value of sum over n of x[n]·A[k][n]. A[k][n] is round(4096·c_k·cos((2n+1)kπ/16)), with c_0 = √(1/8) and c_k = 1/2 for k ≥ 1.
- R2: With the captured mode bit at 1, the same sum uses the orthonormal 8-point Haar rows, all scaled by 4096 and rounded:
  - Row 0 is √(1/8) for every n.
  - Row 1 is +√(1/8) for n<4 and −√(1/8) otherwise.
  - Row 2 is +1/2 at n=0,1, −1/2 at n=2,3, and 0 elsewhere.
  - Row 3 is +1/2 at n=4,5, −1/2 at n=6,7, and 0 elsewhere.
  - Row 4+p (p=0..3) is +√(1/2) at n=2p, −√(1/2) at n=2p+1, and 0 elsewhere.
- R3: Each result is the exact sum plus 2048, arithmetically shifted right by 12 (floor). It is then clamped to the signed OUT_W range: −1024..1023 by default, −256..255 for OUT_W=9.
- R4: Sample n is the unsigned byte samples_in[8n+7:8n]. Result k is the two's-complement field coef_out[OUT_W·k +: OUT_W].
- R5: The sample bus is captured at the first rising edge with rst_n high and then at every 13th edge after that. Values present at any other edge do not affect any result.
- R6: xform_sel is captured only on those same edges. A change between them takes effect with the next group.
- R7: coef_valid is high for exactly one cycle. It rises on the capture edge that ends a group, 13 edges after that group was captured. The first pulse comes at the 14th edge after reset release, and later pulses are 13 cycles apart.
- R8: coef_out changes only on the edge that raises coef_valid and otherwise holds its value.
- R9: While rst_n is low, coef_valid and all results are 0 and the sequencer is idle. Releasing rst_n restarts the timing of R5 and R7 from the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset; low holds the sequencer idle |
| xform_sel | input | 1 | Transform choice: 0 cosine, 1 Haar |
| samples_in | input | 8·SAMPLE_W | Eight unsigned samples, lane n at bits [SAMPLE_W·n +: SAMPLE_W] |
| coef_out | output | 8·OUT_W | Eight signed results, lane k at bits [OUT_W·k +: OUT_W] |
| coef_valid | output | 1 | One-cycle strobe marking a fresh set of results |

## Verification
The bench builds two copies side by side. One uses the default parameters: 12 fractional bits, 13 coefficient planes, a 13-cycle period and 11-bit results. The other is identical except that its results are 9 bits wide. With 8-bit samples the largest exact result magnitude is about 721, so saturation can never occur in the default copy. The narrow copy is driven by the same stimulus and clamps at both its upper and lower bound, which brings the saturation path of R3 within reach. Both modes, all eight rows and all bit planes are exercised by impulse, ramp, step, alternating and pseudo-random groups, with junk driven on the inputs between capture edges.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

   localparam int NPTS = 8;     // points per transform
   localparam int Q_BASE = 12;  // fractional bits of the built-in constants

   typedef enum logic {
      XF_DCT  = 1'b0,
      XF_HAAR = 1'b1
   } xform_e;

   // 4096 * 0.5 * cos(j*pi/16), j = 0..8
   function automatic int half_cos_q(input int j);
      case (j)
         0:       return 2048;
         1:       return 2009;
         2:       return 1892;
         3:       return 1703;
         4:       return 1448;
         5:       return 1138;
         6:       return 784;
         7:       return 400;
         default: return 0;
      endcase
   endfunction

   // Basis weight of output k for sample n, scaled by 2**Q_BASE
   function automatic int basis_q(input logic haar, input int k, input int n);
      int m;
      if (!haar) begin
         if (k == 0) return 1448;
         m = ((2 * n + 1) * k) % 32;
         if (m > 16) m = 32 - m;
         if (m > 8) return -half_cos_q(16 - m);
         return half_cos_q(m);
      end
      case (k)
         0:       return 1448;
         1:       return (n < 4) ? 1448 : -1448;
         2:       return (n < 2) ? 2048 : ((n < 4) ? -2048 : 0);
         3:       return (n < 4) ? 0 : ((n < 6) ? 2048 : -2048);
         default: return (n == 2 * (k - 4)) ? 2896 :
                         ((n == 2 * (k - 4) + 1) ? -2896 : 0);
      endcase
   endfunction

endpackage

// File: rtl/bpx_ctrl.sv
module bpx_ctrl #(
   parameter int PERIOD = 13,
   parameter int COEF_W = 13,
   parameter int SEL_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             grp_load,
   output logic             grp_emit,
   output logic             plane_first,
   output logic             plane_act,
   output logic [SEL_W-1:0] plane_sel
);

   localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             primed_q;

   assign grp_load    = (cnt_q == LAST);
   assign grp_emit    = grp_load & primed_q;
   assign plane_first = (cnt_q == '0);
   assign plane_act   = (int'(cnt_q) < COEF_W);
   assign plane_sel   = plane_act ? SEL_W'(COEF_W - 1 - int'(cnt_q)) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= LAST;
         primed_q <= 1'b0;
      end else begin
         cnt_q    <= grp_load ? '0 : cnt_q + 1'b1;
         primed_q <= primed_q | grp_load;
      end
   end

endmodule

// File: rtl/bpx_adder_net.sv
module bpx_adder_net
   import bpx_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int FRAC     = 12,
   parameter int COEF_W   = 13,
   parameter int PS_W     = 11,
   parameter int MUX_N    = 16
) (
   input  xform_e                                     mode,
   input  logic [NPTS-1:0][SAMPLE_W-1:0]              x,
   output logic [NPTS-1:0][MUX_N-1:0][PS_W-1:0]       planes
);

   // For each lane and plane: add every sample whose weight has that bit set.
   always_comb begin
      planes = '0;
      for (int k = 0; k < NPTS; k++) begin
         for (int b = 0; b < COEF_W; b++) begin
            for (int n = 0; n < NPTS; n++) begin
               int c;
               c = basis_q(mode == XF_HAAR, k, n) <<< (FRAC - Q_BASE);
               if (c[b]) planes[k][b] = planes[k][b] + PS_W'(x[n]);
            end
         end
      end
   end

endmodule

// File: rtl/bpx_accum.sv
module bpx_accum #(
   parameter int PS_W   = 11,
   parameter int MUX_N  = 16,
   parameter int SEL_W  = 4,
   parameter int FRAC   = 12,
   parameter int OUT_W  = 11,
   parameter int ACC_W  = 25
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [MUX_N-1:0][PS_W-1:0]  planes,
   input  logic [SEL_W-1:0]            plane_sel,
   input  logic                        plane_first,
   input  logic                        plane_act,
   input  logic                        grp_emit,
   output logic signed [OUT_W-1:0]     result
);

   localparam int SH_W = ACC_W - FRAC;
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (FRAC - 1));

   logic signed [ACC_W-1:0] acc_q, acc_d, pick_s, rounded, shifted;
   logic signed [OUT_W-1:0] res_d;

   assign pick_s  = signed'(ACC_W'(planes[plane_sel]));
   assign rounded = acc_d + HALF;
   assign shifted = rounded >>> FRAC;

   // Sign plane arrives first and carries negative weight.
   always_comb begin
      if (!plane_act)       acc_d = acc_q;
      else if (plane_first) acc_d = '0 - pick_s;
      else                  acc_d = (acc_q <<< 1) + pick_s;
   end

   if (SH_W > OUT_W) begin : g_clamp
      localparam logic signed [ACC_W-1:0] HI = ACC_W'(2 ** (OUT_W - 1) - 1);
      localparam logic signed [ACC_W-1:0] LO = ~HI;
      always_comb begin
         if (shifted > HI)      res_d = HI[OUT_W-1:0];
         else if (shifted < LO) res_d = LO[OUT_W-1:0];
         else                   res_d = shifted[OUT_W-1:0];
      end
   end else begin : g_fit
      assign res_d = OUT_W'(shifted);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         result <= '0;
      end else begin
         if (plane_act) acc_q  <= acc_d;
         if (grp_emit)  result <= res_d;
      end
   end

endmodule

// File: rtl/bpx_xform.sv
module bpx_xform
   import bpx_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int FRAC     = 12,
   parameter int COEF_W   = 13,
   parameter int PERIOD   = 13,
   parameter int OUT_W    = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      xform_sel,
   input  logic [NPTS*SAMPLE_W-1:0]  samples_in,
   output logic [NPTS*OUT_W-1:0]     coef_out,
   output logic                      coef_valid
);

   localparam int PS_W  = SAMPLE_W + $clog2(NPTS);
   localparam int SEL_W = $clog2(COEF_W);
   localparam int MUX_N = 1 << SEL_W;
   localparam int ACC_W = PS_W + COEF_W + 1;

   if (FRAC < Q_BASE)       begin : g_err_frac   $error("FRAC below built-in constant precision"); end
   if (COEF_W < FRAC + 1)   begin : g_err_coef   $error("COEF_W too narrow for the weights"); end
   if (COEF_W > 31)         begin : g_err_wide   $error("COEF_W above 31"); end
   if (PERIOD < COEF_W)     begin : g_err_period $error("PERIOD shorter than the plane count"); end
   if (OUT_W < 2)           begin : g_err_out    $error("OUT_W below 2"); end

   logic                           grp_load, grp_emit, plane_first, plane_act;
   logic [SEL_W-1:0]               plane_sel;
   xform_e                         mode_q;
   logic [NPTS-1:0][SAMPLE_W-1:0]  xbuf;
   logic [NPTS-1:0][MUX_N-1:0][PS_W-1:0] planes;

   bpx_ctrl #(.PERIOD(PERIOD), .COEF_W(COEF_W), .SEL_W(SEL_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .grp_load(grp_load), .grp_emit(grp_emit),
      .plane_first(plane_first), .plane_act(plane_act), .plane_sel(plane_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xbuf       <= '0;
         mode_q     <= XF_DCT;
         coef_valid <= 1'b0;
      end else begin
         coef_valid <= grp_emit;
         if (grp_load) begin
            xbuf   <= samples_in;
            mode_q <= xform_e'(xform_sel);
         end
      end
   end

   bpx_adder_net #(
      .SAMPLE_W(SAMPLE_W), .FRAC(FRAC), .COEF_W(COEF_W), .PS_W(PS_W), .MUX_N(MUX_N)
   ) i_net (.mode(mode_q), .x(xbuf), .planes(planes));

   for (genvar k = 0; k < NPTS; k++) begin : g_lane
      logic signed [OUT_W-1:0] lane_res;
      bpx_accum #(
         .PS_W(PS_W), .MUX_N(MUX_N), .SEL_W(SEL_W), .FRAC(FRAC),
         .OUT_W(OUT_W), .ACC_W(ACC_W)
      ) i_acc (
         .clk(clk), .rst_n(rst_n), .planes(planes[k]), .plane_sel(plane_sel),
         .plane_first(plane_first), .plane_act(plane_act), .grp_emit(grp_emit),
         .result(lane_res)
      );
      assign coef_out[k*OUT_W +: OUT_W] = lane_res;
   end

endmodule

// File: rtl/bpx_xform_chk.sv
module bpx_xform_chk #(
   parameter int PERIOD = 13,
   parameter int BUS_W  = 88
) (
   input logic             clk,
   input logic             rst_n,
   input logic             coef_valid,
   input logic [BUS_W-1:0] coef_out,
   input logic             load,
   input logic             mode_q
);

   int  gap;
   bit  seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (coef_valid) begin
         gap  <= 1;
         seen <= 1'b1;
      end else begin
         gap <= gap + 1;
      end
   end

   assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid |=> !coef_valid);

   assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid |-> (gap == (seen ? PERIOD : PERIOD + 1)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !coef_valid |-> $stable(coef_out));

   assert_mode_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mode_q));

   assert_load_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);

endmodule

bind bpx_xform bpx_xform_chk #(.PERIOD(PERIOD), .BUS_W(bpx_pkg::NPTS * OUT_W)) i_bpx_chk (
   .clk(clk), .rst_n(rst_n), .coef_valid(coef_valid), .coef_out(coef_out),
   .load(grp_load), .mode_q(mode_q)
);

// File: tb/test_bpx_xform.sv
module test_bpx_xform;

   localparam int OW_A = 11;
   localparam int OW_B = 9;
   localparam int NG   = 48;
   localparam real PI  = 3.14159265358979;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xform_sel = 1'b0;
   logic [63:0] samples_in = '0;
   logic [8*OW_A-1:0] out_a;
   logic [8*OW_B-1:0] out_b;
   logic vld_a, vld_b;

   always #4 clk = ~clk;

   bpx_xform i_bpx_xform (
      .clk(clk), .rst_n(rst_n), .xform_sel(xform_sel), .samples_in(samples_in),
      .coef_out(out_a), .coef_valid(vld_a)
   );

   bpx_xform #(.OUT_W(OW_B)) i_bpx_xform_sat (
      .clk(clk), .rst_n(rst_n), .xform_sel(xform_sel), .samples_in(samples_in),
      .coef_out(out_b), .coef_valid(vld_b)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;
   int exp_a[8], exp_b[8], nxt_a[8], nxt_b[8];
   int cur_mode = 0, nxt_mode = 0;
   logic [8*OW_A-1:0] last_a = '0;
   logic [8*OW_B-1:0] last_b = '0;
   int junk = 12345;

   function automatic int ref_w(int mode, int k, int n);
      real v;
      if (mode == 0) begin
         v = ((k == 0) ? $sqrt(0.125) : 0.5) * $cos(real'((2 * n + 1) * k) * PI / 16.0);
      end else begin
         case (k)
            0: v = $sqrt(0.125);
            1: v = (n < 4) ? $sqrt(0.125) : -$sqrt(0.125);
            2: v = (n < 2) ? 0.5 : ((n < 4) ? -0.5 : 0.0);
            3: v = (n < 4) ? 0.0 : ((n < 6) ? 0.5 : -0.5);
            default: v = (n == 2 * (k - 4)) ? $sqrt(0.5) :
                         ((n == 2 * (k - 4) + 1) ? -$sqrt(0.5) : 0.0);
         endcase
      end
      return int'(v * 4096.0);
   endfunction

   function automatic int pat(int g, int n);
      case ((g / 2) % 8)
         0: return 0;
         1: return 255;
         2: return (n == (g / 16 + g) % 8) ? 255 : 0;
         3: return n * 36;
         4: return (n % 2 == 1) ? 0 : 255;
         5: return (n < 4) ? 0 : 255;
         6: return ((g * 37 + n * 113 + n * n * 29) ^ (g * n * 7)) & 255;
         default: return 255 - n * 33;
      endcase
   endfunction

   function automatic int ref_out(int mode, int g, int k, int ow);
      int acc, r, hi, lo;
      acc = 0;
      for (int n = 0; n < 8; n++)
         acc += ((g < 0) ? 0 : pat(g, n)) * ref_w(mode, k, n);
      r  = (acc + 2048) >>> 12;
      hi = (1 << (ow - 1)) - 1;
      lo = -hi - 1;
      if (r > hi) r = hi;
      if (r < lo) r = lo;
      return r;
   endfunction

   task automatic check(bit ok, string what, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: got %0d expected %0d", what, act, expv);
      end
   endtask

   // Drive group g (g<0: all zeros, cosine mode) and compute its expectation.
   task automatic drive_group(int g);
      nxt_mode = (g < 0) ? 0 : ((g % 2) ^ ((g / 16) % 2));
      for (int n = 0; n < 8; n++)
         samples_in[8*n +: 8] = (g < 0) ? 8'd0 : 8'(pat(g, n));
      xform_sel = nxt_mode[0];
      for (int k = 0; k < 8; k++) begin
         nxt_a[k] = ref_out(nxt_mode, g, k, OW_A);
         nxt_b[k] = ref_out(nxt_mode, g, k, OW_B);
      end
   endtask

   task automatic drive_junk();
      junk = junk * 1103515245 + 12345;
      samples_in = {junk, junk * 7 + 3};
      xform_sel  = ~xform_sel;
   endtask

   task automatic quiet();
      check(!vld_a && !vld_b, "R7 no strobe inside a group period", int'(vld_a) + int'(vld_b), 0);
      check(out_a == last_a && out_b == last_b, "R8 results held between strobes",
            int'(out_a == last_a && out_b == last_b), 1);
   endtask

   // Entered at the first falling edge after a capture edge.
   task automatic window(int next_g);
      string tag;
      drive_junk();                           // R5 R6: junk between captures
      for (int j = 1; j < 12; j++) begin
         @(negedge clk);
         quiet();
         drive_junk();
      end
      @(negedge clk);
      quiet();
      drive_group(next_g);
      @(negedge clk);
      check(vld_a && vld_b, "R7 strobe 13 cycles after capture", int'(vld_a) + int'(vld_b), 2);
      tag = (cur_mode == 0) ? "R1" : "R2";
      for (int k = 0; k < 8; k++) begin
         check($signed(out_a[k*OW_A +: OW_A]) == exp_a[k],
               $sformatf("%s lane %0d (R4 R5 R6 capture only)", tag, k),
               $signed(out_a[k*OW_A +: OW_A]), exp_a[k]);
         check($signed(out_b[k*OW_B +: OW_B]) == exp_b[k],
               $sformatf("R3 clamp lane %0d", k),
               $signed(out_b[k*OW_B +: OW_B]), exp_b[k]);
      end
      last_a = out_a;
      last_b = out_b;
      exp_a = nxt_a;
      exp_b = nxt_b;
      cur_mode = nxt_mode;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!vld_a && !vld_b && out_a == '0 && out_b == '0, "R9 idle in reset",
            int'(vld_a) + int'(out_a != '0), 0);
      drive_group(0);
      exp_a = nxt_a;
      exp_b = nxt_b;
      cur_mode = nxt_mode;
      rst_n = 1'b1;
      @(negedge clk);
      quiet();
      for (int g = 0; g < NG; g++)
         window((g + 1 < NG) ? g + 1 : -1);

      // R9: reset in mid-group, then restart with a saturating group
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(!vld_a && !vld_b && out_a == '0 && out_b == '0, "R9 cleared by reset",
            int'(vld_a) + int'(out_a != '0), 0);
      drive_group(3);
      exp_a = nxt_a;
      exp_b = nxt_b;
      cur_mode = nxt_mode;
      last_a = '0;
      last_b = '0;
      rst_n = 1'b1;
      @(negedge clk);
      quiet();
      window(-1);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule